// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the status word of an asynchronous serial receiver/transmitter. The datapath reports each event as a single-cycle pulse. The block catches that pulse in a sticky flag and shows it at a fixed bit of a 32-bit read word. The events are:

- framing failure
- receive-buffer overrun
- parity failure
- break
- wake-up
- idle line
- busy
- receive ready
- transmit ready
- transmit empty
- receive wake
- transmit wake

Software clears flags by writing ones over them. Three other sources also clear flags:

- A read of an error interrupt vector clears the matching error flag.
- A newly received character clears the framing flag.
- A software reset or a module reset returns every flag to its reset value.

The three error flags are each gated by an enable bit. The enabled flags combine into one error interrupt line.

Event inputs arrive as a 12-bit vector. Each bit index maps to one flag, and the requirements give the mapping. The serial shifters, the baud timing and the bus fabric sit outside this block.

Top module: `ssf_status_reg`

## Requirements
- R1: The read word `rd_data` has these fields:
  - framing error at bit 26, overrun at bit 25, parity error at bit 24
  - receive-wake at bit 12, transmit-empty at bit 11, transmit-wake at bit 10, receive-ready at bit 9, transmit-ready at bit 8
  - busy at bit 3, idle at bit 2, wake-up at bit 1, break at bit 0
  - every other bit (31:27, 23:16, 15:13, 7:4) reads 0.
- R2: `rst_n` is a synchronous active-low reset. At the first clock edge where it is low, transmit-empty and transmit-ready become 1 and every other flag becomes 0, so `rd_data` reads 0x00000900.
- R3: `set_ev` bit k sets flag k at the next clock edge. The flag stays set after the pulse ends. The index mapping is:
  - 0 break, 1 wake-up, 2 idle, 3 busy
  - 4 transmit-ready, 5 receive-ready, 6 transmit-wake, 7 transmit-empty
  - 8 receive-wake, 9 parity, 10 overrun, 11 framing.
- R4: With `wr_en` high, a 1 in `wr_data` at a flag's bit position clears that flag at the next edge. A 0 leaves the flag unchanged. Writes to reserved bit positions have no effect.
- R5: While `sw_rst` or `mod_rst` is high, every flag returns to its R2 reset value at the next edge. This holds even if a set event arrives in the same cycle.
- R6: A `vec_rd` strobe clears one error flag, selected by `vec_code`:
  - 1 clears parity
  - 2 clears overrun
  - 3 clears framing
  - 0 clears nothing.
  No other flag is touched.
- R7: A `new_char` pulse clears the framing flag and no other flag.
- R8: When a set event and a write-one clear, a vector read or a `new_char` clear land in the same cycle, the set event wins and the flag ends up set.
- R9: `err_irq` is high exactly when at least one error flag is set and its enable is high. The enables in `int_en` are: bit 0 parity, bit 1 overrun, bit 2 framing. The output follows the flags and enables in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| sw_rst | input | 1 | Software reset level, restores reset values |
| mod_rst | input | 1 | Module reset level, restores reset values |
| set_ev | input | 12 | Single-cycle event pulses, one per flag (R3 mapping) |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, ones clear flags |
| vec_rd | input | 1 | Interrupt vector read strobe |
| vec_code | input | 2 | Vector being read: 1 parity, 2 overrun, 3 framing |
| new_char | input | 1 | A new character was received |
| int_en | input | 3 | Error interrupt enables: parity, overrun, framing |
| rd_data | output | 32 | Status word |
| err_irq | output | 1 | Error interrupt |

## Verification
The flag logic is tried with several patterns:
- Lone event pulses show that each flag latches at its own position and stays set.
- Writes of zeros, of reserved-only bits and of all ones separate a true write-one clear from a write that must change nothing.
- Vector reads with each code, including code 0, and `new_char` pulses show that only the intended flag clears.

Cycles that carry a set event together with each kind of clear expose a wrong priority. Soft resets paired with events show that the resets win. Enable patterns that select one error flag at a time show whether the interrupt follows the right flag.

// File: rtl/ssf_pkg.sv
// Shared constants for the serial status flag register.
// Assumes a 32-bit read word and twelve flags indexed as in the brief.
package ssf_pkg;
    localparam int REG_W     = 32;
    localparam int NUM_FLAGS = 12;
    localparam int NUM_ERR   = 3;
    localparam int CODE_W    = 2;

    // Flag indices with special behaviour.
    localparam int IDX_PARITY  = 9;
    localparam int IDX_OVERRUN = 10;
    localparam int IDX_FRAMING = 11;

    // Bit position of flag k in the read word.
    function automatic int flag_pos(input int k);
        case (k)
            0:  return 0;
            1:  return 1;
            2:  return 2;
            3:  return 3;
            4:  return 8;
            5:  return 9;
            6:  return 10;
            7:  return 11;
            8:  return 12;
            9:  return 24;
            10: return 25;
            default: return 26;
        endcase
    endfunction

    // Value flag k takes on any reset.
    function automatic logic flag_rst(input int k);
        return (k == 4) || (k == 7);
    endfunction

    // Vector code that clears flag k (0 means none).
    function automatic logic [CODE_W-1:0] flag_vec(input int k);
        case (k)
            IDX_PARITY:  return 2'd1;
            IDX_OVERRUN: return 2'd2;
            IDX_FRAMING: return 2'd3;
            default:     return 2'd0;
        endcase
    endfunction

    // Mask of implemented bits in the read word.
    function automatic logic [REG_W-1:0] used_mask();
        logic [REG_W-1:0] m;
        m = '0;
        for (int k = 0; k < NUM_FLAGS; k++) begin
            m[flag_pos(k)] = 1'b1;
        end
        return m;
    endfunction
endpackage

// File: rtl/ssf_flag_cell.sv
// One sticky status flag.
// Priority from highest: system reset, soft reset, set event, clear request.
// Assumes all inputs are synchronous to clk.
module ssf_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic soft_clr,
    input  logic set_ev,
    input  logic clr_req,
    output logic q
);
    // Flag state update with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)        q <= RST_VAL;
        else if (soft_clr) q <= RST_VAL;
        else if (set_ev)   q <= 1'b1;
        else if (clr_req)  q <= 1'b0;
    end

    assert_set_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && !soft_clr) |=> q);
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ev && !clr_req && !soft_clr) |=> $stable(q));
    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_ev && !soft_clr) |=> !q);
    assert_soft_reset_R5: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (q == RST_VAL));
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && clr_req && !soft_clr) |=> q);
endmodule

// File: rtl/ssf_irq_gate.sv
// Combines the enabled error flags into one interrupt line.
// Assumes the flag and enable vectors share bit order.
module ssf_irq_gate #(
    parameter int N = 3
) (
    input  logic [N-1:0] flags,
    input  logic [N-1:0] en,
    output logic         irq
);
    // Enabled-flag reduction.
    always_comb irq = |(flags & en);
endmodule

// File: rtl/ssf_status_reg.sv
// Serial port status flag register.
// Latches datapath event pulses as sticky flags and clears them by:
//   - write-one-to-clear
//   - an error vector read
//   - a new character (framing flag only)
//   - a soft reset.
// Drives an error interrupt from the enabled error flags.
// Assumes single-cycle event pulses, with sw_rst and mod_rst as levels.
module ssf_status_reg
    import ssf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sw_rst,
    input  logic                 mod_rst,
    input  logic [NUM_FLAGS-1:0] set_ev,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_data,
    input  logic                 vec_rd,
    input  logic [CODE_W-1:0]    vec_code,
    input  logic                 new_char,
    input  logic [NUM_ERR-1:0]   int_en,
    output logic [REG_W-1:0]     rd_data,
    output logic                 err_irq
);
    localparam logic [REG_W-1:0] USED = used_mask();

    logic                 soft_clr;
    logic [NUM_FLAGS-1:0] flag_q;
    logic [NUM_FLAGS-1:0] clr_req;
    logic [NUM_ERR-1:0]   err_flags;

    // Either soft reset restores reset values.
    always_comb soft_clr = sw_rst | mod_rst;

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        localparam int               POS  = flag_pos(k);
        localparam logic [CODE_W-1:0] CODE = flag_vec(k);
        localparam logic             IS_FR = (k == IDX_FRAMING);

        // Collect this flag's clear sources.
        always_comb begin
            clr_req[k] = wr_en & wr_data[POS];
            if (CODE != '0) clr_req[k] = clr_req[k] | (vec_rd & (vec_code == CODE));
            if (IS_FR)      clr_req[k] = clr_req[k] | new_char;
        end

        ssf_flag_cell #(.RST_VAL(flag_rst(k))) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_clr (soft_clr),
            .set_ev   (set_ev[k]),
            .clr_req  (clr_req[k]),
            .q        (flag_q[k])
        );
    end

    // Place each flag at its bit of the read word.
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NUM_FLAGS; k++) rd_data[flag_pos(k)] = flag_q[k];
    end

    // Error flags in enable order: parity, overrun, framing.
    always_comb err_flags = {flag_q[IDX_FRAMING], flag_q[IDX_OVERRUN], flag_q[IDX_PARITY]};

    ssf_irq_gate #(.N(NUM_ERR)) u_irq (
        .flags (err_flags),
        .en    (int_en),
        .irq   (err_irq)
    );

    assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & ~USED) == '0);
    assert_vec_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && vec_code == 2'd2 && !set_ev[IDX_OVERRUN] && !soft_clr) |=> !rd_data[25]);
    assert_newchar_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (new_char && !set_ev[IDX_FRAMING] && !soft_clr) |=> !rd_data[26]);
    assert_irq_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (int_en != '0));
endmodule

// File: tb/ssf_status_reg_test.sv
// Bench for the serial status flag register.
// A vector table is walked first, then directed reset and corner cases.
module ssf_status_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sw_rst = 1'b0, mod_rst = 1'b0;
    logic [11:0] set_ev = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        vec_rd = 1'b0;
    logic [1:0]  vec_code = '0;
    logic        new_char = 1'b0;
    logic [2:0]  int_en = '0;
    logic [31:0] rd_data;
    logic        err_irq;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ssf_status_reg uut (.*);

    typedef struct packed {
        logic [11:0] ev;
        logic        wr;
        logic [31:0] wd;
        logic        vr;
        logic [1:0]  vc;
        logic        nc;
        logic [2:0]  en;
        logic [31:0] exp_rd;
        logic        exp_irq;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{12'h200, 1'b0, 32'h0,        1'b0, 2'd0, 1'b0, 3'b000, 32'h01000900, 1'b0, 4'd3}, // R3 parity sets
        '{12'h000, 1'b0, 32'h0,        1'b0, 2'd0, 1'b0, 3'b001, 32'h01000900, 1'b1, 4'd9}, // R9 sticky, enabled
        '{12'hC00, 1'b0, 32'h0,        1'b0, 2'd0, 1'b0, 3'b001, 32'h07000900, 1'b1, 4'd3}, // R3 overrun+framing
        '{12'h000, 1'b1, 32'h01000000, 1'b0, 2'd0, 1'b0, 3'b001, 32'h06000900, 1'b0, 4'd4}, // R4 W1C parity
        '{12'h000, 1'b1, 32'h00000000, 1'b0, 2'd0, 1'b0, 3'b010, 32'h06000900, 1'b1, 4'd4}, // R4 zeros keep
        '{12'h000, 1'b0, 32'h0,        1'b1, 2'd2, 1'b0, 3'b010, 32'h04000900, 1'b0, 4'd6}, // R6 overrun vector
        '{12'h000, 1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 3'b100, 32'h00000900, 1'b0, 4'd7}, // R7 new char
        '{12'h16F, 1'b0, 32'h0,        1'b0, 2'd0, 1'b0, 3'b000, 32'h00001F0F, 1'b0, 4'd1}, // R1 positions
        '{12'h000, 1'b1, 32'hF8FFE0F0, 1'b0, 2'd0, 1'b0, 3'b000, 32'h00001F0F, 1'b0, 4'd4}, // R4 reserved write
        '{12'h000, 1'b1, 32'hFFFFFFFF, 1'b0, 2'd0, 1'b0, 3'b111, 32'h00000000, 1'b0, 4'd4}, // R4 clear all
        '{12'h090, 1'b0, 32'h0,        1'b0, 2'd0, 1'b0, 3'b111, 32'h00000900, 1'b0, 4'd3}, // R3 tx flags
        '{12'h800, 1'b0, 32'h0,        1'b1, 2'd3, 1'b0, 3'b100, 32'h04000900, 1'b1, 4'd8}, // R8 vs vector
        '{12'h200, 1'b1, 32'h01000000, 1'b0, 2'd0, 1'b0, 3'b001, 32'h05000900, 1'b1, 4'd8}, // R8 vs W1C
        '{12'h400, 1'b0, 32'h0,        1'b0, 2'd0, 1'b1, 3'b011, 32'h03000900, 1'b1, 4'd8}, // R8 vs new char
        '{12'h000, 1'b0, 32'h0,        1'b1, 2'd1, 1'b0, 3'b001, 32'h02000900, 1'b0, 4'd6}, // R6 parity vector
        '{12'h000, 1'b0, 32'h0,        1'b1, 2'd0, 1'b0, 3'b010, 32'h02000900, 1'b1, 4'd6}  // R6 code 0 no-op
    };

    task automatic check(input int req, input logic [31:0] exp_rd, input logic exp_irq);
        checks++;
        if (rd_data !== exp_rd || err_irq !== exp_irq) begin
            errors++;
            $display("FAIL R%0d rd_data=%h irq=%b expected rd_data=%h irq=%b",
                     req, rd_data, err_irq, exp_rd, exp_irq);
        end
    endtask

    // Apply one cycle of stimulus, release pulses, sample mid-cycle.
    task automatic step();
        @(posedge clk);
        #1;
        set_ev = '0; wr_en = 0; wr_data = '0; vec_rd = 0; vec_code = '0;
        new_char = 0; sw_rst = 0; mod_rst = 0;
        #2;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        int_en = 3'b111;
        #1;
        check(2, 32'h00000900, 1'b0);            // R2 reset state
        @(negedge clk) rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            set_ev = TBL[i].ev; wr_en = TBL[i].wr; wr_data = TBL[i].wd;
            vec_rd = TBL[i].vr; vec_code = TBL[i].vc; new_char = TBL[i].nc;
            int_en = TBL[i].en;
            step();
            check(int'(TBL[i].req), TBL[i].exp_rd, TBL[i].exp_irq);
        end

        // R5 software reset beats a same-cycle event.
        @(negedge clk); sw_rst = 1; set_ev = 12'h200; int_en = 3'b111;
        step();
        check(5, 32'h00000900, 1'b0);

        // R3 every event at once.
        @(negedge clk); set_ev = 12'hFFF;
        step();
        check(3, 32'h07001F0F, 1'b1);

        // R5 module reset restores reset values.
        @(negedge clk); mod_rst = 1;
        step();
        check(5, 32'h00000900, 1'b0);

        // R2 system reset mid-run.
        @(negedge clk); set_ev = 12'hFFF;
        step();
        @(negedge clk); rst_n = 0;
        @(posedge clk); #3;
        check(2, 32'h00000900, 1'b0);
        @(negedge clk) rst_n = 1;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule